// File: doc/BRIEF.md
# Real-Time Clock Register Interface

This block keeps the time of day and the calendar date, and exposes them through a pair of byte ports. A write to the index port selects an internal register. A later read of the data port returns that register. Seconds, minutes, hours, day of week, day of month, month and year are held as binary counters. A one-cycle load strobe presets them from a set of initialization inputs. A one-second tick input then advances them, carrying through a fixed, non-leap days-per-month table.

Some indices return control values rather than time fields. One status register returns an update-in-progress flag that flips on every read of that register. Two others return fixed encodings. The remaining control index, and any unmapped index, return an error. Any write to the data port also returns an error.

A separate generator drives a periodic interrupt. It emits a one-cycle pulse every `irq_period` clock cycles and re-arms itself without software help.

Top module: `rtc_index_port`

## Requirements
- R1: A write with `bus_wr_data_port`=0 stores `bus_wdata[7:0]` as the register index, and the index resets to 0x00. A `bus_rd` pulse gives `bus_rvalid`=1 on the next cycle, with the selected value on `bus_rdata`. The index map is 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 day of week (0..6), 0x07 day of month, 0x08 month and 0x09 year.
- R2: Index 0x0A returns `{flag, 7'h26}`, where the flag resets to 1 and inverts after every read of index 0x0A. Reads of other indices leave the flag unchanged, so reads of 0x0A give 0xA6, 0x26, 0xA6 and so on.
- R3: Index 0x0B always returns 0x46 and index 0x0C always returns 0x00.
- R4: A read of index 0x0D, or of any index not listed in R1 to R3, returns 0x00 and raises `bus_err` in the same cycle as `bus_rvalid`. A valid read leaves `bus_err` low.
- R5: A write with `bus_wr_data_port`=1 raises `bus_err` one cycle later. It changes neither the index nor any time field.
- R6: The month is reported 1-based (January = 1). The year is reported as the stored years-since-1900 value minus 52, modulo 256.
- R7: `init_load` presets every time field on the next edge, with month 0-based and year in years since 1900. When `init_load` and `tick_1s` are high in the same cycle, the load wins.
- R8: Each tick adds one second. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0 and carry into the date.
- R9: A day carry wraps day of week from 6 to 0. Day of month wraps to 1 after the month's last day and advances the month. Month lengths are 31, 28, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 (no leap day). December wraps to January and increments the year.
- R10: With `irq_period`=N>0, `periodic_irq` is a one-cycle pulse repeating every N cycles with no rewrite. With `irq_period`=0 it stays low.
- R11: After reset, the fields read back as 0 seconds, 0 minutes, 0 hours, day of week 0, day of month 1, month 1 and year 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-second advance strobe |
| init_load | input | 1 | Preset strobe for all time fields |
| init_sec | input | 6 | Preset seconds |
| init_min | input | 6 | Preset minutes |
| init_hour | input | 5 | Preset hours (0..23) |
| init_wday | input | 3 | Preset day of week (0..6) |
| init_mday | input | 5 | Preset day of month (1..31) |
| init_month | input | 4 | Preset month, 0-based |
| init_year | input | 8 | Preset years since 1900 |
| bus_wr | input | 1 | Write strobe |
| bus_wr_data_port | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Data-port read strobe |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| bus_err | output | 1 | Unsupported access indication |
| irq_period | input | PERIOD_W | Interrupt interval in cycles, 0 disables |
| periodic_irq | output | 1 | Periodic interrupt pulse |

## Verification
The hardest case to reach from the ports is the full carry from 23:59:59 on the last day of a month. It must ripple into the weekday, the date, the month and, for December, the year. Waiting for it in ticks would take tens of millions of cycles. The bench instead presets the clock one or two seconds before each boundary through the load inputs. It then ticks across the boundary, covering December, February and a 30-day month. The update-in-progress flag is exercised by interleaving reads of other indices between reads of status register A.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] year;   // years since 1900
    logic [3:0] mon;    // 0-based
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hrs;
    logic [5:0] mins;
    logic [5:0] secs;
  } rtc_time_t;

  localparam logic [7:0] IDX_SEC   = 8'h00;
  localparam logic [7:0] IDX_MIN   = 8'h02;
  localparam logic [7:0] IDX_HOUR  = 8'h04;
  localparam logic [7:0] IDX_WDAY  = 8'h06;
  localparam logic [7:0] IDX_MDAY  = 8'h07;
  localparam logic [7:0] IDX_MON   = 8'h08;
  localparam logic [7:0] IDX_YEAR  = 8'h09;
  localparam logic [7:0] IDX_STA   = 8'h0A;
  localparam logic [7:0] IDX_STB   = 8'h0B;
  localparam logic [7:0] IDX_STC   = 8'h0C;

  localparam logic [7:0] STA_LOW   = 8'h26;
  localparam logic [7:0] STB_VALUE = 8'h46;
  localparam logic [7:0] STC_VALUE = 8'h00;
  localparam logic [7:0] YEAR_BIAS = 8'd52;

  function automatic logic [4:0] month_len(input logic [3:0] m);
    case (m)
      4'd1:                   month_len = 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10: month_len = 5'd30;
      default:                month_len = 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_clock_core.sv
module rtc_clock_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  rtc_time_t init_i,
  input  logic      tick_i,
  output rtc_time_t time_o
);

  rtc_time_t t_q, t_d;

  always_comb begin
    t_d = t_q;
    if (load_i) begin
      t_d = init_i;
    end else if (tick_i) begin
      if (t_q.secs >= 6'd59) begin
        t_d.secs = '0;
        if (t_q.mins >= 6'd59) begin
          t_d.mins = '0;
          if (t_q.hrs >= 5'd23) begin
            t_d.hrs  = '0;
            t_d.wday = (t_q.wday >= 3'd6) ? 3'd0 : t_q.wday + 3'd1;
            if (t_q.mday >= month_len(t_q.mon)) begin
              t_d.mday = 5'd1;
              if (t_q.mon >= 4'd11) begin
                t_d.mon  = '0;
                t_d.year = t_q.year + 8'd1;
              end else begin
                t_d.mon = t_q.mon + 4'd1;
              end
            end else begin
              t_d.mday = t_q.mday + 5'd1;
            end
          end else begin
            t_d.hrs = t_q.hrs + 5'd1;
          end
        end else begin
          t_d.mins = t_q.mins + 6'd1;
        end
      end else begin
        t_d.secs = t_q.secs + 6'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q      <= '0;
      t_q.mday <= 5'd1;
      t_q.year <= YEAR_BIAS;
    end else if (load_i || tick_i) begin
      t_q <= t_d;
    end
  end

  assign time_o = t_q;

endmodule

// File: rtl/rtc_pulse_gen.sv
module rtc_pulse_gen #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                pulse_o
);

  logic [PERIOD_W-1:0] cnt_q, cnt_d;
  logic                pulse_q, pulse_d;
  logic                enabled;
  logic                at_end;

  assign enabled = (period_i != '0);
  assign at_end  = (cnt_q >= period_i - PERIOD_W'(1));

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (!enabled) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d   = '0;
      pulse_d = 1'b1;
    end else begin
      cnt_d = cnt_q + PERIOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

endmodule

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
  import rtc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              wr_data_port_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  rtc_time_t         time_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  output logic [7:0]        index_o,
  output logic              uip_o
);

  logic [7:0]        idx_q, idx_d;
  logic              uip_q, uip_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              err_q, err_d;
  logic [7:0]        sel_val;
  logic              sel_bad;
  logic [7:0]        year_rep;

  assign year_rep = time_i.year - YEAR_BIAS;

  always_comb begin
    sel_bad = 1'b0;
    case (idx_q)
      IDX_SEC:  sel_val = {2'b00, time_i.secs};
      IDX_MIN:  sel_val = {2'b00, time_i.mins};
      IDX_HOUR: sel_val = {3'b000, time_i.hrs};
      IDX_WDAY: sel_val = {5'b00000, time_i.wday};
      IDX_MDAY: sel_val = {3'b000, time_i.mday};
      IDX_MON:  sel_val = {4'b0000, time_i.mon} + 8'd1;
      IDX_YEAR: sel_val = year_rep;
      IDX_STA:  sel_val = STA_LOW | {uip_q, 7'b0};
      IDX_STB:  sel_val = STB_VALUE;
      IDX_STC:  sel_val = STC_VALUE;
      default: begin
        sel_val = 8'h00;
        sel_bad = 1'b1;
      end
    endcase
  end

  always_comb begin
    idx_d    = idx_q;
    uip_d    = uip_q;
    rdata_d  = '0;
    rvalid_d = 1'b0;
    err_d    = 1'b0;
    if (wr_i) begin
      if (wr_data_port_i) err_d = 1'b1;
      else                idx_d = wdata_i[7:0];
    end
    if (rd_i) begin
      rvalid_d = 1'b1;
      rdata_d  = DATA_W'(sel_val);
      if (sel_bad) err_d = 1'b1;
      if (idx_q == IDX_STA) uip_d = ~uip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      uip_q    <= 1'b1;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      uip_q    <= uip_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
  assign index_o  = idx_q;
  assign uip_o    = uip_q;

endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1s,
  input  logic                init_load,
  input  logic [5:0]          init_sec,
  input  logic [5:0]          init_min,
  input  logic [4:0]          init_hour,
  input  logic [2:0]          init_wday,
  input  logic [4:0]          init_mday,
  input  logic [3:0]          init_month,
  input  logic [7:0]          init_year,
  input  logic                bus_wr,
  input  logic                bus_wr_data_port,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic                bus_rd,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  output logic                bus_err,
  input  logic [PERIOD_W-1:0] irq_period,
  output logic                periodic_irq
);

  rtc_time_t init_time;
  rtc_time_t cur_time;
  logic [7:0] reg_index;
  logic       uip_flag;

  always_comb begin
    init_time.secs = init_sec;
    init_time.mins = init_min;
    init_time.hrs  = init_hour;
    init_time.wday = init_wday;
    init_time.mday = init_mday;
    init_time.mon  = init_month;
    init_time.year = init_year;
  end

  rtc_clock_core u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (init_load),
    .init_i (init_time),
    .tick_i (tick_1s),
    .time_o (cur_time)
  );

  rtc_port_decode #(.DATA_W(DATA_W)) u_dec (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_i           (bus_wr),
    .wr_data_port_i (bus_wr_data_port),
    .wdata_i        (bus_wdata),
    .rd_i           (bus_rd),
    .time_i         (cur_time),
    .rdata_o        (bus_rdata),
    .rvalid_o       (bus_rvalid),
    .err_o          (bus_err),
    .index_o        (reg_index),
    .uip_o          (uip_flag)
  );

  rtc_pulse_gen #(.PERIOD_W(PERIOD_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (irq_period),
    .pulse_o  (periodic_irq)
  );

endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk #(
  parameter int PERIOD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic                bus_wr_data_port,
  input logic                bus_rvalid,
  input logic                bus_err,
  input logic                tick_1s,
  input logic                init_load,
  input logic [5:0]          sec_now,
  input logic [7:0]          reg_index,
  input logic                uip_flag,
  input logic [PERIOD_W-1:0] irq_period,
  input logic                periodic_irq
);

  assert_rvalid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_uip_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && reg_index == 8'h0A) |=> (uip_flag != $past(uip_flag)));

  assert_uip_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || reg_index != 8'h0A) |=> $stable(uip_flag));

  assert_err_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_err) |-> $past(bus_rd || bus_wr));

  assert_data_write_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wr_data_port) |=> bus_err);

  assert_data_write_keeps_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wr_data_port) |=> $stable(reg_index));

  assert_sec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1s && !init_load && sec_now < 6'd59) |=> (sec_now == $past(sec_now) + 6'd1));

  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_irq && irq_period > 1) |=> (!periodic_irq || irq_period <= 1));

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_period) == '0) |-> !periodic_irq);

endmodule

bind rtc_index_port rtc_index_port_chk #(.PERIOD_W(PERIOD_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_rd           (bus_rd),
  .bus_wr           (bus_wr),
  .bus_wr_data_port (bus_wr_data_port),
  .bus_rvalid       (bus_rvalid),
  .bus_err          (bus_err),
  .tick_1s          (tick_1s),
  .init_load        (init_load),
  .sec_now          (cur_time.secs),
  .reg_index        (reg_index),
  .uip_flag         (uip_flag),
  .irq_period       (irq_period),
  .periodic_irq     (periodic_irq)
);

// File: tb/rtc_index_port_test.sv
module rtc_index_port_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_1s, init_load;
  logic [5:0]  init_sec, init_min;
  logic [4:0]  init_hour, init_mday;
  logic [2:0]  init_wday;
  logic [3:0]  init_month;
  logic [7:0]  init_year;
  logic        bus_wr, bus_wr_data_port, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        bus_rvalid, bus_err;
  logic [15:0] irq_period;
  logic        periodic_irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_index_port uut (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .init_load(init_load),
    .init_sec(init_sec), .init_min(init_min), .init_hour(init_hour),
    .init_wday(init_wday), .init_mday(init_mday), .init_month(init_month),
    .init_year(init_year), .bus_wr(bus_wr), .bus_wr_data_port(bus_wr_data_port),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .irq_period(irq_period),
    .periodic_irq(periodic_irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic rd_reg(input logic set_idx, input logic [7:0] idx,
                        input logic [7:0] exp, input logic exp_err, input string tag);
    if (set_idx) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_wr_data_port = 1'b0; bus_wdata = idx;
      @(negedge clk);
      bus_wr = 1'b0;
    end else begin
      @(negedge clk);
    end
    bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " rvalid"}, int'(bus_rvalid), 1);
    check({tag, " data"}, int'(bus_rdata), int'(exp));
    check({tag, " err"}, int'(bus_err), int'(exp_err));
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic do_load(input int s, input int m, input int h, input int wd,
                         input int md, input int mo, input int y);
    @(negedge clk);
    init_sec = 6'(s); init_min = 6'(m); init_hour = 5'(h); init_wday = 3'(wd);
    init_mday = 5'(md); init_month = 4'(mo); init_year = 8'(y);
    init_load = 1'b1;
    @(negedge clk);
    init_load = 1'b0;
  endtask

  task automatic test_reset();
    rd_reg(1'b0, 8'h00, 8'd0, 1'b0, "R11 R1 sec at reset via reset index");
    rd_reg(1'b1, 8'h02, 8'd0, 1'b0, "R11 min");
    rd_reg(1'b1, 8'h04, 8'd0, 1'b0, "R11 hour");
    rd_reg(1'b1, 8'h06, 8'd0, 1'b0, "R11 wday");
    rd_reg(1'b1, 8'h07, 8'd1, 1'b0, "R11 mday");
    rd_reg(1'b1, 8'h08, 8'd1, 1'b0, "R11 R6 month");
    rd_reg(1'b1, 8'h09, 8'd0, 1'b0, "R11 R6 year");
  endtask

  task automatic test_status();
    rd_reg(1'b1, 8'h0A, 8'hA6, 1'b0, "R2 first read");
    rd_reg(1'b0, 8'h0A, 8'h26, 1'b0, "R2 second read");
    rd_reg(1'b1, 8'h00, 8'd0,  1'b0, "R2 other index");
    rd_reg(1'b1, 8'h0A, 8'hA6, 1'b0, "R2 third read");
    rd_reg(1'b1, 8'h0B, 8'h46, 1'b0, "R3 reg B");
    rd_reg(1'b0, 8'h0B, 8'h46, 1'b0, "R3 reg B again");
    rd_reg(1'b1, 8'h0C, 8'h00, 1'b0, "R3 reg C");
  endtask

  task automatic test_errors();
    rd_reg(1'b1, 8'h0D, 8'h00, 1'b1, "R4 reg D");
    rd_reg(1'b1, 8'h01, 8'h00, 1'b1, "R4 unknown 0x01");
    rd_reg(1'b1, 8'h3F, 8'h00, 1'b1, "R4 unknown 0x3F");
    do_load(7, 33, 5, 2, 10, 4, 100);
    rd_reg(1'b1, 8'h02, 8'd33, 1'b0, "R5 before data write");
    @(negedge clk);
    bus_wr = 1'b1; bus_wr_data_port = 1'b1; bus_wdata = 8'h55;
    @(negedge clk);
    bus_wr = 1'b0; bus_wr_data_port = 1'b0;
    check("R5 err after data write", int'(bus_err), 1);
    rd_reg(1'b0, 8'h02, 8'd33, 1'b0, "R5 index and minutes kept");
    rd_reg(1'b1, 8'h00, 8'd7, 1'b0, "R5 seconds kept");
  endtask

  task automatic test_load();
    do_load(58, 59, 23, 6, 31, 11, 125);
    rd_reg(1'b1, 8'h00, 8'd58, 1'b0, "R7 sec");
    rd_reg(1'b1, 8'h02, 8'd59, 1'b0, "R7 min");
    rd_reg(1'b1, 8'h04, 8'd23, 1'b0, "R7 hour");
    rd_reg(1'b1, 8'h06, 8'd6,  1'b0, "R7 wday");
    rd_reg(1'b1, 8'h07, 8'd31, 1'b0, "R7 mday");
    rd_reg(1'b1, 8'h08, 8'd12, 1'b0, "R6 month December");
    rd_reg(1'b1, 8'h09, 8'd73, 1'b0, "R6 year 125-52");
  endtask

  task automatic test_year_roll();
    do_tick();
    rd_reg(1'b1, 8'h00, 8'd59, 1'b0, "R8 sec step");
    rd_reg(1'b1, 8'h02, 8'd59, 1'b0, "R8 min held");
    do_tick();
    rd_reg(1'b1, 8'h00, 8'd0, 1'b0, "R8 sec wrap");
    rd_reg(1'b1, 8'h02, 8'd0, 1'b0, "R8 min wrap");
    rd_reg(1'b1, 8'h04, 8'd0, 1'b0, "R8 hour wrap");
    rd_reg(1'b1, 8'h06, 8'd0, 1'b0, "R9 wday wrap");
    rd_reg(1'b1, 8'h07, 8'd1, 1'b0, "R9 mday wrap");
    rd_reg(1'b1, 8'h08, 8'd1, 1'b0, "R9 month to January");
    rd_reg(1'b1, 8'h09, 8'd74, 1'b0, "R9 year increment");
  endtask

  task automatic test_month_ends();
    do_load(59, 59, 23, 2, 28, 1, 100);
    do_tick();
    rd_reg(1'b1, 8'h07, 8'd1, 1'b0, "R9 February 28 wrap");
    rd_reg(1'b1, 8'h08, 8'd3, 1'b0, "R9 to March");
    rd_reg(1'b1, 8'h06, 8'd3, 1'b0, "R9 wday step");
    do_load(59, 59, 23, 0, 30, 3, 100);
    do_tick();
    rd_reg(1'b1, 8'h07, 8'd1, 1'b0, "R9 April 30 wrap");
    rd_reg(1'b1, 8'h08, 8'd5, 1'b0, "R9 to May");
    do_load(59, 59, 23, 0, 30, 0, 100);
    do_tick();
    rd_reg(1'b1, 8'h07, 8'd31, 1'b0, "R9 January 30 to 31");
    rd_reg(1'b1, 8'h08, 8'd1, 1'b0, "R9 still January");
    do_load(10, 59, 4, 0, 3, 0, 100);
    do_tick();
    rd_reg(1'b1, 8'h02, 8'd59, 1'b0, "R8 min kept below 59 sec");
    do_load(59, 59, 4, 0, 3, 0, 100);
    do_tick();
    rd_reg(1'b1, 8'h04, 8'd5, 1'b0, "R8 hour carry");
    rd_reg(1'b1, 8'h07, 8'd3, 1'b0, "R8 no day carry before 23h");
  endtask

  task automatic test_load_priority();
    @(negedge clk);
    init_sec = 6'd20; init_min = 6'd1; init_hour = 5'd1; init_wday = 3'd1;
    init_mday = 5'd1; init_month = 4'd0; init_year = 8'd90;
    init_load = 1'b1; tick_1s = 1'b1;
    @(negedge clk);
    init_load = 1'b0; tick_1s = 1'b0;
    rd_reg(1'b1, 8'h00, 8'd20, 1'b0, "R7 load beats tick");
  endtask

  task automatic test_irq();
    int n;
    bit seen;
    @(negedge clk);
    irq_period = 16'd10;
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      @(negedge clk);
      if (periodic_irq) seen = 1;
    end
    check("R10 irq seen", int'(seen), 1);
    @(negedge clk);
    check("R10 pulse width", int'(periodic_irq), 0);
    n = 1;
    while (!periodic_irq && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R10 interval 10", n, 10);
    n = 0;
    @(negedge clk);
    n = 1;
    while (!periodic_irq && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R10 re-armed interval", n, 10);
    irq_period = 16'd0;
    @(negedge clk);
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (periodic_irq) seen = 1;
    end
    check("R10 disabled stays low", int'(seen), 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick_1s = 1'b0; init_load = 1'b0;
    init_sec = '0; init_min = '0; init_hour = '0; init_wday = '0;
    init_mday = '0; init_month = '0; init_year = '0;
    bus_wr = 1'b0; bus_wr_data_port = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    irq_period = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 rvalid low after reset", int'(bus_rvalid), 0);
    check("R10 irq low after reset", int'(periodic_irq), 0);
    test_reset();
    test_status();
    test_errors();
    test_load();
    test_year_roll();
    test_month_ends();
    test_load_priority();
    test_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule